// File: doc/BRIEF.md
# Pixel Clock Synthesizer Word Calculator

This block converts a requested pixel clock period, given in picoseconds, into the programming word for an external frequency synthesizer. A start pulse captures a 32-bit period. The block then derives the target frequency in units of 0.01 MHz and rejects out-of-range requests. For a valid request it chooses a power-of-two output divider that lifts the frequency into the synthesizer's oscillator band. It then computes a rounded feedback count and packs that count, the divider code and a fixed pair of stop bits into one word.

The request takes three long divisions: the period to frequency conversion, the reference ratio, and the rounding step. All three share one 32-step restoring divider, so the time from start to done is fixed and small. Done pulses for one cycle. On that cycle the error flag, the word, the chosen post divider and a location address are valid, and they hold until the next result. Shifting the word out to the synthesizer happens outside this block.

Top module: `pllw_calc`

## Requirements
- R1: The frequency in 0.01 MHz units is the integer quotient 100000000 / period. A period of 0 is treated as an infinitely high frequency.
- R2: A frequency above 15938 or below 1000 ends the request with err high, word 0 and post_div 0.
- R3: For an accepted frequency, post_div is the smallest of 1, 2, 4, 8 such that frequency × post_div is at least 8000. The frequency is doubled once for each step.
- R4: The feedback count is ((scaled frequency × 46000) / 1432 + 500) / 1000, with each division truncating.
- R5: The word is laid out as follows. The feedback count minus 257 sits in bits 8:0. Bits 10:9 hold the divider code: 3 for post_div 1, 2 for 2, 1 for 4, 0 for 8. Bits 12:11 are always 1, and bits 15:13 are 0.
- R6: loc_addr is always 0.
- R7: done is high for exactly one cycle per accepted start. busy is high from the cycle after start until done, and low when done is high.
- R8: A start that arrives while busy is ignored. It produces no result of its own and does not change the result in progress.
- R9: done rises no more than 115 clock cycles after the edge that captures start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| period_ps | input | 32 | Requested pixel clock period in picoseconds |
| busy | output | 1 | A request is being computed |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Request out of range |
| word | output | 16 | Synthesizer programming word |
| loc_addr | output | 5 | Synthesizer register location, always 0 |
| post_div | output | 4 | Chosen post divider value (1, 2, 4 or 8; 0 on error) |

## Verification
The hardest cases to reach are the edges of the divider choice and of the range check. A period near 12500 ps lands exactly on the 8000 floor, or one unit below it. One unit below forces a doubling to 15998, which is above the upper accept limit. A period of 100000 ps needs all three doublings. The stimulus therefore picks periods whose integer quotients fall just on and just off 1000, 8000 and 15938, and it adds 0 and all-ones periods. To show that a second start is ignored, another start with a different period is raised in the middle of a computation. The bench then watches for any extra done or a changed result.

// File: rtl/pllw_pkg.sv
// Package: constants and types shared by the synthesizer word calculator.
// Assumes all arithmetic fits in 32 bits for frequencies up to 16000.
package pllw_pkg;

    localparam int unsigned FREQ_SCALE  = 100_000_000; // ps -> 0.01 MHz numerator
    localparam int unsigned FREQ_HI     = 15938;       // highest accepted frequency
    localparam int unsigned FREQ_LO     = 1000;        // lowest accepted frequency
    localparam int unsigned FREQ_FLOOR  = 8000;        // oscillator band floor
    localparam int unsigned REF_MUL     = 46000;       // reference ratio numerator x1000
    localparam int unsigned REF_DIV     = 1432;        // reference frequency
    localparam int unsigned ROUND_ADD   = 500;         // half unit for rounding
    localparam int unsigned ROUND_DIV   = 1000;        // rounding scale
    localparam int unsigned CNT_OFFSET  = 257;         // subtracted from the count
    localparam logic [15:0] STOP_MASK   = 16'h1800;    // always-set stop bits
    localparam int unsigned CODE_LSB    = 9;           // divider code position

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREQ,
        ST_CHECK,
        ST_SCALE,
        ST_RATIO,
        ST_ROUND,
        ST_PACK
    } calc_state_t;

    // Divider code: larger post division gives a smaller code.
    function automatic logic [1:0] pd_code(input logic [3:0] pd);
        case (pd)
            4'd1:    pd_code = 2'd3;
            4'd2:    pd_code = 2'd2;
            4'd4:    pd_code = 2'd1;
            default: pd_code = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/pllw_div.sv
// Module: restoring unsigned divider, one quotient bit per cycle.
// A go pulse loads operands; valid pulses for one cycle W+1 cycles later,
// with the quotient held until the next go. Divisor 0 yields all ones.
// Assumes go is not raised while a division is running.
module pllw_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         valid,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dsr_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          valid_q;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    // Shift-in of the next dividend bit and trial subtraction.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dsr_q};
    end

    // Iteration registers: load on go, then one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            quo_q   <= '0;
            dsr_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo_q <= dividend;
                dsr_q <= divisor;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign valid    = valid_q;
    assign quotient = quo_q;

    // R9: the divider result strobe lasts one cycle
    p_div_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R9: the controller never restarts a running division
    p_div_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> !go);

endmodule

// File: rtl/pllw_pack.sv
// Module: combinational packer of the programming word.
// Places (count - offset) in the low bits, the inverted divider code
// above it, and ORs in the stop bits. Assumes WORD_W >= 13.
module pllw_pack #(
    parameter int WORD_W = 16,
    parameter int PD_W   = 4
) (
    input  logic [WORD_W-1:0] count,
    input  logic [PD_W-1:0]   pd,
    output logic [WORD_W-1:0] word
);
    import pllw_pkg::*;

    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] code_field;

    // Word assembly from offset count, code field and stop bits.
    always_comb begin
        base       = count - WORD_W'(CNT_OFFSET);
        code_field = WORD_W'(pd_code(4'(pd))) << CODE_LSB;
        word       = base | code_field | WORD_W'(STOP_MASK);
    end

endmodule

// File: rtl/pllw_calc.sv
// Module: top of the synthesizer word calculator.
// Sequences one shared divider through frequency, reference ratio and
// rounding; range-checks and scales the frequency by doubling; registers
// the packed result with a one-cycle done strobe. Start is only sampled
// while idle. Assumes period_ps is stable on the start cycle only.
module pllw_calc #(
    parameter int PERIOD_W = 32,
    parameter int WORD_W   = 16,
    parameter int LOC_W    = 5,
    parameter int PD_W     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [PERIOD_W-1:0] period_ps,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [WORD_W-1:0]   word,
    output logic [LOC_W-1:0]    loc_addr,
    output logic [PD_W-1:0]     post_div
);
    import pllw_pkg::*;

    calc_state_t         state_q;
    logic                go_q;
    logic [PERIOD_W-1:0] a_q;
    logic [PERIOD_W-1:0] b_q;
    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] freq_q;
    logic [PERIOD_W-1:0] count_q;
    logic [PD_W-1:0]     pd_q;
    logic                div_valid;
    logic [PERIOD_W-1:0] div_quo;
    logic [WORD_W-1:0]   packed_word;
    logic                done_q;
    logic                err_q;
    logic [WORD_W-1:0]   word_q;
    logic [PD_W-1:0]     pdo_q;

    pllw_div #(.W(PERIOD_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go_q),
        .dividend (a_q),
        .divisor  (b_q),
        .valid    (div_valid),
        .quotient (div_quo)
    );

    pllw_pack #(.WORD_W(WORD_W), .PD_W(PD_W)) u_pack (
        .count (count_q[WORD_W-1:0]),
        .pd    (pd_q),
        .word  (packed_word)
    );

    // Sequencer: steps through the three divisions and the result update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            go_q     <= 1'b0;
            a_q      <= '0;
            b_q      <= '0;
            period_q <= '0;
            freq_q   <= '0;
            count_q  <= '0;
            pd_q     <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            word_q   <= '0;
            pdo_q    <= '0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        period_q <= period_ps;
                        a_q      <= PERIOD_W'(FREQ_SCALE);
                        b_q      <= period_ps;
                        go_q     <= 1'b1;
                        state_q  <= ST_FREQ;
                    end
                end
                ST_FREQ: begin
                    if (div_valid) begin
                        freq_q  <= div_quo;
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (freq_q > PERIOD_W'(FREQ_HI) || freq_q < PERIOD_W'(FREQ_LO)) begin
                        err_q   <= 1'b1;
                        word_q  <= '0;
                        pdo_q   <= '0;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        pd_q    <= PD_W'(1);
                        state_q <= ST_SCALE;
                    end
                end
                ST_SCALE: begin
                    if (freq_q < PERIOD_W'(FREQ_FLOOR)) begin
                        freq_q <= freq_q << 1;
                        pd_q   <= pd_q << 1;
                    end else begin
                        a_q     <= freq_q * PERIOD_W'(REF_MUL);
                        b_q     <= PERIOD_W'(REF_DIV);
                        go_q    <= 1'b1;
                        state_q <= ST_RATIO;
                    end
                end
                ST_RATIO: begin
                    if (div_valid) begin
                        a_q     <= div_quo + PERIOD_W'(ROUND_ADD);
                        b_q     <= PERIOD_W'(ROUND_DIV);
                        go_q    <= 1'b1;
                        state_q <= ST_ROUND;
                    end
                end
                ST_ROUND: begin
                    if (div_valid) begin
                        count_q <= div_quo;
                        state_q <= ST_PACK;
                    end
                end
                ST_PACK: begin
                    err_q   <= 1'b0;
                    word_q  <= packed_word;
                    pdo_q   <= pd_q;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign word     = word_q;
    assign loc_addr = '0;
    assign post_div = pdo_q;

    // R7: done is a single-cycle strobe
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: an accepted start makes the block busy on the next cycle
    p_busy_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R8: a start during a computation leaves the captured period alone
    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(period_q));

    // R2: a rejected request carries no word and no divider
    p_err_no_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (word == '0 && post_div == '0));

    // R5: stop bits set and top bits clear on every accepted word
    p_stop_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (word[12:11] == 2'b11 && word[WORD_W-1:13] == '0));

    // R3: an accepted result names exactly one power-of-two divider
    p_pd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> ($countones(post_div) == 1 && post_div <= PD_W'(8)));

    // R4: the rounded count is small enough for the word field
    p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PACK) |-> (count_q[PERIOD_W-1:10] == '0));

endmodule

// File: tb/tb_pllw_calc.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task queues the expected result of each
// request; a monitor pops and compares on every done strobe.
module tb_pllw_calc;

    typedef struct {
        logic        e;
        logic [15:0] w;
        logic [3:0]  pd;
        logic [31:0] p;
    } exp_t;

    logic        clk;
    logic        rst_n;
    logic        start;
    logic [31:0] period_ps;
    logic        busy;
    logic        done;
    logic        err;
    logic [15:0] word;
    logic [4:0]  loc_addr;
    logic [3:0]  post_div;

    int   n_tests;
    int   n_fail;
    exp_t sb_q[$];

    pllw_calc dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .period_ps (period_ps),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .word      (word),
        .loc_addr  (loc_addr),
        .post_div  (post_div)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Independent model of R1-R5.
    function automatic exp_t model(input logic [31:0] p);
        exp_t   r;
        longint f;
        longint c;
        longint cd;
        r.p = p;
        if (p == 0) f = 64'h1_0000_0000;            // R1 zero period
        else        f = 100000000 / longint'(p);
        if (f > 15938 || f < 1000) begin            // R2
            r.e = 1'b1; r.w = 16'h0; r.pd = 4'd0;
        end else begin
            r.e  = 1'b0;
            r.pd = 4'd1;
            while (f < 8000) begin f = f * 2; r.pd = r.pd << 1; end // R3
            c = ((f * 46000) / 1432 + 500) / 1000;  // R4
            case (r.pd)
                4'd1: cd = 3;
                4'd2: cd = 2;
                4'd4: cd = 1;
                default: cd = 0;
            endcase
            r.w = 16'(((c - 257) & 16'hFFFF) | (cd << 9) | 16'h1800); // R5
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    // Driver: queue the expectation, pulse start, time the result (R7, R9).
    task automatic run_req(input logic [31:0] p);
        int lat;
        sb_q.push_back(model(p));
        @(negedge clk);
        start = 1'b1; period_ps = p;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7", $sformatf("busy after start: got %0b exp 1", busy));
        lat = 1;
        while (!done && lat < 200) begin @(negedge clk); lat++; end
        check(lat <= 115, "R9", $sformatf("latency p=%0d got %0d exp <=115", p, lat));
        check(busy == 1'b0, "R7", $sformatf("busy at done: got %0b exp 0", busy));
        @(negedge clk);
        check(done == 1'b0, "R7", $sformatf("done width: got %0b exp 0", done));
    endtask

    // Monitor: compare each done against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8", $sformatf("unexpected done: got word %h exp none", word));
            end else begin
                exp_t x;
                x = sb_q.pop_front();
                check(err == x.e, "R2", $sformatf("err p=%0d got %0b exp %0b", x.p, err, x.e));
                check(word == x.w, "R4 R5", $sformatf("word p=%0d got %h exp %h", x.p, word, x.w));
                check(post_div == x.pd, "R3", $sformatf("post_div p=%0d got %0d exp %0d", x.p, post_div, x.pd));
                check(loc_addr == 5'd0, "R6", $sformatf("loc_addr got %0d exp 0", loc_addr));
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        n_tests = 0; n_fail = 0;
        rst_n = 1'b0; start = 1'b0; period_ps = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err && word == 0 && post_div == 0 && loc_addr == 0,
              "R7", $sformatf("reset state: got b%0b d%0b e%0b w%h exp all 0", busy, done, err, word));

        run_req(32'd10000);     // R1 R4 mid band, post_div 1
        run_req(32'd6275);      // R4 near top
        run_req(32'd6274);      // R2 exactly 15938 accepted
        run_req(32'd6273);      // R2 just above limit
        run_req(32'd12500);     // R3 exactly on floor
        run_req(32'd12501);     // R3 one below floor, doubles
        run_req(32'd20000);     // R3 post_div 2
        run_req(32'd40000);     // R3 post_div 4
        run_req(32'd100000);    // R3 post_div 8, f=1000 accepted
        run_req(32'd100001);    // R2 just below lower limit
        run_req(32'd0);         // R1 R2 zero period
        run_req(32'd1);         // R2 huge frequency
        run_req(32'hFFFF_FFFF); // R2 tiny frequency
        run_req(32'd15384);     // R4 rounding case
        run_req(32'd33145);     // R3 R4

        // R8: second start during computation is ignored.
        sb_q.push_back(model(32'd17460));
        @(negedge clk);
        start = 1'b1; period_ps = 32'd17460;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1; period_ps = 32'd7395;
        @(negedge clk);
        start = 1'b0;
        repeat (250) @(negedge clk);
        check(sb_q.size() == 0, "R8", $sformatf("pending results got %0d exp 0", sb_q.size()));
        check(!busy, "R8", $sformatf("busy after ignored start got %0b exp 0", busy));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule